// File: doc/BRIEF.md
# Profile-Pin Multi-Level Modulation Channel

This block is a single channel of a direct digital synthesis modulator. Up to four external profile pins pick one of sixteen stored words. That word drives one chosen parameter of the channel: the frequency tuning word, the phase offset, or the output amplitude. The channel can therefore act as a 2-, 4-, 8- or 16-level FSK, PSK or ASK source.

A 32-bit phase accumulator adds the active frequency word on every clock. The top 14 accumulator bits are added to the active phase offset to form the phase word. A 10-bit amplitude is divided by a power of two, set by a 2-bit full-scale code. Both results are registered and go to a downstream angle-to-amplitude converter.

Software sets up the channel through a simple write port. Profile 0 of the modulated parameter always comes from that parameter's own base register. Profiles 1 to 15 come from a bank of 32-bit entries, and phase and amplitude values are taken from the top bits of each entry.

Top module: `prof_mod_chan`

## Requirements
- R1: While reset is held and after it is released, `phase_out` and `amp_out` are 0, the accumulator is 0, and every control and base register is 0.
- R2: The level field (control bits [3:2]) holds n, and only pins [n:0] are used: 1, 2, 3 or 4 pins for 2, 4, 8 or 16 levels. The profile index is the pin value with the higher pins forced to 0.
- R3: A profile index of 0 selects the base register of the modulated parameter. An index k from 1 to 15 selects bank entry k.
- R4: The mode field (control bits [1:0]) picks the modulated parameter: 00 none, 01 frequency, 10 phase, 11 amplitude. Every parameter that is not modulated comes from its base register, whatever the pin value.
- R5: A frequency profile uses all 32 bits of a bank entry. A phase profile uses entry bits [31:18] and an amplitude profile uses entry bits [31:22]. The lower bits of the entry are ignored.
- R6: The accumulator adds the active frequency word on every clock, modulo 2^32. `phase_out` is accumulator bits [31:18] plus the active phase word, modulo 2^14. When the frequency word is a multiple of 2^18, two consecutive `phase_out` values differ by the frequency word shifted right by 18, modulo 2^14.
- R7: The full-scale code sits in control bits [5:4]. `amp_out` is the active amplitude shifted right by a number of bits set by that code: 11 shifts by 0, 01 by 1, 10 by 2 and 00 by 3.
- R8: A change on the profile pins reaches `phase_out` or `amp_out` on the fourth rising clock edge after the change. This is two synchronizer stages, one bank-read stage and one output register.
- R9: The write address map is: 0 for control, 1 for the base frequency, 2 for the base phase (data bits [13:0]), 3 for the base amplitude (data bits [9:0]), and 17 to 31 for bank entries 1 to 15. A base or control write affects the outputs at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 32 | Register write data |
| prof_pins | input | 4 | Asynchronous profile select pins |
| phase_out | output | 14 | Phase word for the angle-to-amplitude converter |
| amp_out | output | 10 | Scaled amplitude |

## Verification
A wrong profile index or a wrong bank word appears at `phase_out` or `amp_out` four clocks after the pins change. The bench sweeps every pin value at every level count, so a masking or alignment fault shows up as a wrong word on the first sample. An accumulator fault does not show as a fixed value. It shows as a wrong step between two consecutive phase words, and that step can be seen within one clock of settling. A leak of the pins into a parameter that should not be modulated shows on the other output in the same cycle.

// File: rtl/modchan_pkg.sv
package modchan_pkg;

  typedef enum logic [1:0] {
    MOD_NONE  = 2'b00,
    MOD_FREQ  = 2'b01,
    MOD_PHASE = 2'b10,
    MOD_AMP   = 2'b11
  } mod_sel_e;

  // Full-scale code to right-shift count: 11->0, 01->1, 10->2, 00->3
  function automatic logic [1:0] fs_to_shift(input logic [1:0] code);
    case (code)
      2'b11:   return 2'd0;
      2'b01:   return 2'd1;
      2'b10:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/modchan_pin_sync.sv
module modchan_pin_sync #(
  parameter int PIN_W  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIN_W-1:0] pins_in,
  output logic [PIN_W-1:0] pins_out
);

  logic [PIN_W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= pins_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign pins_out = chain[STAGES-1];

endmodule

// File: rtl/modchan_prof_bank.sv
module modchan_prof_bank #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);

  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // Simple dual-port memory with a registered read port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/modchan_word_sel.sv
module modchan_word_sel
  import modchan_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 14,
  parameter int AMP_W   = 10,
  parameter int IDX_W   = 4
) (
  input  mod_sel_e           mode,
  input  logic [IDX_W-1:0]   idx,
  input  logic [FREQ_W-1:0]  bank_word,
  input  logic [FREQ_W-1:0]  base_freq,
  input  logic [PHASE_W-1:0] base_phase,
  input  logic [AMP_W-1:0]   base_amp,
  output logic [FREQ_W-1:0]  freq_act,
  output logic [PHASE_W-1:0] phase_act,
  output logic [AMP_W-1:0]   amp_act
);

  logic from_bank;
  assign from_bank = (idx != '0);

  always_comb begin
    freq_act  = base_freq;
    phase_act = base_phase;
    amp_act   = base_amp;
    if (from_bank) begin
      case (mode)
        MOD_FREQ:  freq_act  = bank_word;
        MOD_PHASE: phase_act = bank_word[FREQ_W-1 -: PHASE_W];
        MOD_AMP:   amp_act   = bank_word[FREQ_W-1 -: AMP_W];
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/modchan_dds_core.sv
module modchan_dds_core #(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 14,
  parameter int AMP_W   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FREQ_W-1:0]  freq_word,
  input  logic [PHASE_W-1:0] phase_word,
  input  logic [AMP_W-1:0]   amp_word,
  input  logic [1:0]         shift,
  output logic [PHASE_W-1:0] phase_out,
  output logic [AMP_W-1:0]   amp_out
);

  logic [FREQ_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      phase_out <= '0;
      amp_out   <= '0;
    end else begin
      acc_q     <= acc_q + freq_word;
      phase_out <= acc_q[FREQ_W-1 -: PHASE_W] + phase_word;
      amp_out   <= amp_word >> shift;
    end
  end

  // R6: a zero tuning word holds the accumulator still
  a_r6_acc_hold: assert property (@(posedge clk) disable iff (rst)
    (freq_word == '0) |=> $stable(acc_q));

  // R1: reset clears the outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (phase_out == '0 && amp_out == '0));

endmodule

// File: rtl/prof_mod_chan.sv
module prof_mod_chan
  import modchan_pkg::*;
#(
  parameter int FREQ_W      = 32,
  parameter int PHASE_W     = 14,
  parameter int AMP_W       = 10,
  parameter int PIN_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [PIN_W:0]      wr_addr,
  input  logic [FREQ_W-1:0]   wr_data,
  input  logic [PIN_W-1:0]    prof_pins,
  output logic [PHASE_W-1:0]  phase_out,
  output logic [AMP_W-1:0]    amp_out
);

  localparam int LVL_W  = $clog2(PIN_W);
  localparam int LVL_LO = 2;
  localparam int FS_LO  = LVL_LO + LVL_W;

  // Control and base registers
  mod_sel_e           mode_q;
  logic [LVL_W-1:0]   lvl_q;
  logic [1:0]         fs_q;
  logic [FREQ_W-1:0]  base_freq_q;
  logic [PHASE_W-1:0] base_phase_q;
  logic [AMP_W-1:0]   base_amp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q       <= MOD_NONE;
      lvl_q        <= '0;
      fs_q         <= '0;
      base_freq_q  <= '0;
      base_phase_q <= '0;
      base_amp_q   <= '0;
    end else if (wr_en && !wr_addr[PIN_W]) begin
      case (wr_addr[PIN_W-1:0])
        0: begin
          mode_q <= mod_sel_e'(wr_data[1:0]);
          lvl_q  <= wr_data[LVL_LO +: LVL_W];
          fs_q   <= wr_data[FS_LO +: 2];
        end
        1:       base_freq_q  <= wr_data;
        2:       base_phase_q <= wr_data[PHASE_W-1:0];
        3:       base_amp_q   <= wr_data[AMP_W-1:0];
        default: ;
      endcase
    end
  end

  logic bank_we;
  assign bank_we = wr_en && wr_addr[PIN_W] && (wr_addr[PIN_W-1:0] != '0);

  // Pin synchronizer and level mask
  logic [PIN_W-1:0] pins_s;
  logic [PIN_W-1:0] lvl_mask;
  logic [PIN_W-1:0] prof_idx;
  logic [PIN_W-1:0] idx_q;

  modchan_pin_sync #(.PIN_W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .pins_in (prof_pins),
    .pins_out(pins_s)
  );

  assign lvl_mask = PIN_W'((32'd1 << (32'(lvl_q) + 32'd1)) - 32'd1);
  assign prof_idx = pins_s & lvl_mask;

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else     idx_q <= prof_idx;
  end

  // Profile bank
  logic [FREQ_W-1:0] bank_word;

  modchan_prof_bank #(.WORD_W(FREQ_W), .IDX_W(PIN_W)) u_bank (
    .clk  (clk),
    .we   (bank_we),
    .waddr(wr_addr[PIN_W-1:0]),
    .wdata(wr_data),
    .raddr(prof_idx),
    .rdata(bank_word)
  );

  // Word selection
  logic [FREQ_W-1:0]  freq_act;
  logic [PHASE_W-1:0] phase_act;
  logic [AMP_W-1:0]   amp_act;

  modchan_word_sel #(
    .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .AMP_W(AMP_W), .IDX_W(PIN_W)
  ) u_sel (
    .mode      (mode_q),
    .idx       (idx_q),
    .bank_word (bank_word),
    .base_freq (base_freq_q),
    .base_phase(base_phase_q),
    .base_amp  (base_amp_q),
    .freq_act  (freq_act),
    .phase_act (phase_act),
    .amp_act   (amp_act)
  );

  logic [1:0] shift;
  assign shift = fs_to_shift(fs_q);

  modchan_dds_core #(.FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .freq_word (freq_act),
    .phase_word(phase_act),
    .amp_word  (amp_act),
    .shift     (shift),
    .phase_out (phase_out),
    .amp_out   (amp_out)
  );

  // R2: the latched index never uses pins above the level setting
  a_r2_index_within_levels: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((idx_q & ~$past(lvl_mask)) == '0));

  // R4: amplitude follows its base register when not modulated
  a_r4_unmod_amp: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MOD_AMP) |=> (amp_out == AMP_W'($past(base_amp_q) >> $past(shift))));

  // R7: scaled amplitude stays under the attenuated full scale
  a_r7_scale_bound: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ({1'b0, amp_out} <= ((AMP_W+1)'((1 << AMP_W) - 1) >> $past(shift))));

endmodule

// File: tb/tb_prof_mod_chan.sv
`timescale 1ns/1ps
module tb_prof_mod_chan;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  prof_pins = '0;
  logic [13:0] phase_out;
  logic [9:0]  amp_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prof_mod_chan dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prof_pins(prof_pins), .phase_out(phase_out), .amp_out(amp_out)
  );

  localparam int BASE_PH  = 'h2ABC;
  localparam int BASE_AMP = 'h2C5;

  function automatic logic [31:0] ent(input int k);
    return 32'(k) * 32'h9E37_79B1 + 32'h0BAD_F00D;
  endfunction

  function automatic logic [31:0] fent(input int k);
    return 32'((k * 397 + 11) % 16384) << 18;
  endfunction

  function automatic int shamt(input int fs);
    case (fs)
      3: return 0;
      1: return 1;
      2: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ctrl(input int mode, input int lvl, input int fs);
    wr(0, 32'(mode) | (32'(lvl) << 2) | (32'(fs) << 4));
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int idx, exp_v, ph0, ph1, f;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 phase", int'(phase_out), 0);
    chk("R1 amp", int'(amp_out), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 phase after release", int'(phase_out), 0);

    // R9 map: program base registers and bank entries
    wr(2, 32'hFFFF_0000 | BASE_PH);
    wr(3, 32'hFFFF_FC00 | BASE_AMP);
    for (int k = 1; k < 16; k++) wr(16 + k, ent(k));

    // Phase modulation, frequency 0 so accumulator stays 0: R2 R3 R5 R4
    for (int lvl = 0; lvl < 4; lvl++) begin
      ctrl(2, lvl, lvl);
      for (int p = 0; p < 16; p++) begin
        prof_pins = 4'(p);
        settle();
        idx = p & ((1 << (lvl + 1)) - 1);
        exp_v = (idx == 0) ? BASE_PH : int'(ent(idx) >> 18);
        chk("R2 R3 R5 phase profile", int'(phase_out), exp_v);
        chk("R4 amp unmodulated", int'(amp_out), BASE_AMP >> shamt(lvl));
      end
    end

    // Amplitude modulation with all scale codes: R2 R3 R5 R7 R4
    for (int lvl = 0; lvl < 4; lvl++) begin
      for (int fs = 0; fs < 4; fs++) begin
        ctrl(3, lvl, fs);
        for (int p = 0; p < 16; p++) begin
          prof_pins = 4'(p);
          settle();
          idx = p & ((1 << (lvl + 1)) - 1);
          exp_v = (idx == 0) ? BASE_AMP : int'(ent(idx) >> 22);
          chk("R7 R5 amp profile", int'(amp_out), exp_v >> shamt(fs));
          chk("R4 phase unmodulated", int'(phase_out), BASE_PH);
        end
      end
    end

    // No modulation: pins have no effect (R4)
    ctrl(0, 3, 3);
    for (int p = 0; p < 16; p++) begin
      prof_pins = 4'(p);
      settle();
      chk("R4 none phase", int'(phase_out), BASE_PH);
      chk("R4 none amp", int'(amp_out), BASE_AMP);
    end

    // Latency: R8
    ctrl(3, 3, 3);
    prof_pins = 4'd0;
    settle();
    prof_pins = 4'd9;
    for (int e = 1; e <= 4; e++) begin
      @(negedge clk);
      exp_v = (e < 4) ? BASE_AMP : int'(ent(9) >> 22);
      chk("R8 latency", int'(amp_out), exp_v);
    end

    // Frequency modulation: R6 R3 R2
    do_reset();
    wr(1, 32'(123) << 18);
    wr(2, BASE_PH);
    wr(3, BASE_AMP);
    for (int k = 1; k < 16; k++) wr(16 + k, fent(k));
    for (int pass = 0; pass < 2; pass++) begin
      ctrl(1, (pass == 0) ? 3 : 1, 1);
      for (int p = 0; p < 16; p++) begin
        prof_pins = 4'(p);
        settle();
        ph0 = int'(phase_out);
        @(negedge clk);
        ph1 = int'(phase_out);
        idx = p & ((pass == 0) ? 15 : 3);
        f = (idx == 0) ? 123 : int'(fent(idx) >> 18);
        chk("R6 phase step", (ph1 - ph0) & 16383, f & 16383);
        chk("R4 amp in freq mode", int'(amp_out), BASE_AMP >> 1);
      end
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule